// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two unsigned integers by repeated add and shift, using three registers: a double-width multiplicand register that moves left, a single-width multiplier register that moves right, and a double-width product register. A double-width adder feeds the product register. Each iteration looks at the low bit of the multiplier. When that bit is 1, the multiplicand is added into the product. After that, both operand registers move one place. The loop runs once for each operand bit.

The operand width is chosen per operation, from 1 up to the build-time maximum `MAX_W` (32 by default), and the datapath keeps its fixed double width. A host pulses `start` with both operands and the width. It then waits for the one-cycle `done` pulse and reads the product. The block also drives out the contents of all three registers, a step code and the iteration index, so that every intermediate state can be watched from outside.

Top module: `shift_add_mul`

## Requirements
- R1: While reset is held and after it is released, `busy_o`, `done_o`, `product_o`, `mcand_o`, `mplier_o`, `step_o` and `iter_o` are all zero.
- R2: A `start_i` seen while idle loads the registers at that clock edge. The product becomes zero. The multiplicand register holds the masked A in its low half and zeros in its upper half. The multiplier register holds the masked B. `busy_o` goes high.
- R3: In an add step, the product becomes product + multiplicand when multiplier bit 0 is 1. When that bit is 0, the product keeps its value.
- R4: In a shift step, both operand registers move in the same cycle: the multiplicand left by one and the multiplier right by one. Zeros fill the vacated bits.
- R5: The loop runs exactly n iterations, each an add step followed by a shift step, so one operation takes 2n cycles after the load. The final product is the full product of the masked operands.
- R6: `width_i` is sampled at start. A value of 0, or any value above `MAX_W`, selects `MAX_W`. Operand bits at positions n and above are forced to zero before loading.
- R7: `done_o` is high for exactly one cycle, in the cycle after the last shift step, and `busy_o` is low in that same cycle. While idle, the product keeps its value until the next accepted start.
- R8: A `start_i` that arrives while busy has no effect on any register or output.
- R9: `step_o` is 0 when idle, 1 in an add step and 2 in a shift step. `iter_o` holds the zero-based iteration number while busy and returns to 0 when the operation ends.
- R10: With n=6, A=50 and B=10, the product is 500.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only while idle |
| a_i | input | MAX_W | Multiplicand operand A |
| b_i | input | MAX_W | Multiplier operand B |
| width_i | input | $clog2(MAX_W+1) | Operand width n |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| product_o | output | 2*MAX_W | Product register contents |
| mcand_o | output | 2*MAX_W | Multiplicand register contents |
| mplier_o | output | MAX_W | Multiplier register contents |
| step_o | output | 2 | Step code: 0 idle, 1 add, 2 shift |
| iter_o | output | $clog2(MAX_W) | Current iteration index |

## Verification
Two situations are hard to reach from the ports. The first is a start request that lands in the middle of an operation. The second is an operand with stray bits above the selected width, combined with a width of zero or one above the maximum. The stimulus pulses `start_i` with different operands and a different width partway through a run. It also feeds operands that are all ones above bit n together with out-of-range widths. A behavioural model compares all three registers, the step code and the index against the design on every cycle, so any disturbance shows up in the cycle where it happens.

// File: rtl/mul_pkg.sv
// Shared definitions for the shift-add multiplier.
// The state encoding is also the externally visible step code.
package mul_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ADD   = 2'd1,
        ST_SHIFT = 2'd2
    } mul_state_e;
endpackage

// File: rtl/mul_width_ctl.sv
// Width selection and operand masking.
// Assumes: width_i is an unsigned count. Out-of-range values select MAX_W.
module mul_width_ctl #(
    parameter int MAX_W = 32,
    parameter int WW    = $clog2(MAX_W + 1)
) (
    input  logic [WW-1:0]    width_i,
    input  logic [MAX_W-1:0] a_i,
    input  logic [MAX_W-1:0] b_i,
    output logic [WW-1:0]    n_o,
    output logic [MAX_W-1:0] a_mask_o,
    output logic [MAX_W-1:0] b_mask_o
);
    logic [MAX_W-1:0] keep;

    // Clamp the requested width into 1..MAX_W.
    always_comb begin
        if (width_i == '0 || width_i > WW'(MAX_W))
            n_o = WW'(MAX_W);
        else
            n_o = width_i;
    end

    // One keep bit per operand position: set only below the width.
    for (genvar i = 0; i < MAX_W; i++) begin : g_keep
        assign keep[i] = (WW'(i) < n_o);
    end

    assign a_mask_o = a_i & keep;
    assign b_mask_o = b_i & keep;
endmodule

// File: rtl/mul_adder.sv
// Double-width unsigned adder feeding the product register.
// Assumes: the carry out is dropped, since the result fits in 2*MAX_W bits.
module mul_adder #(
    parameter int DW = 64
) (
    input  logic [DW-1:0] x_i,
    input  logic [DW-1:0] y_i,
    output logic [DW-1:0] sum_o
);
    assign sum_o = x_i + y_i;
endmodule

// File: rtl/mul_ctrl.sv
// Sequencer: idle -> (add, shift) x n -> idle, with a one-cycle done pulse.
// Assumes: n_i is already clamped into 1..MAX_W by the width stage.
module mul_ctrl
    import mul_pkg::*;
#(
    parameter int MAX_W = 32,
    parameter int WW    = $clog2(MAX_W + 1),
    parameter int CW    = $clog2(MAX_W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [WW-1:0] n_i,
    output mul_state_e    state_o,
    output logic [CW-1:0] iter_o,
    output logic          load_o,
    output logic          busy_o,
    output logic          done_o
);
    mul_state_e    state_q;
    logic [CW-1:0] iter_q;
    logic [WW-1:0] n_q;
    logic          done_q;
    logic          last;

    assign load_o = start_i && (state_q == ST_IDLE);
    assign last   = (WW'(iter_q) == (n_q - WW'(1)));

    // Step sequencing, iteration counting and done pulse generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            iter_q  <= '0;
            n_q     <= WW'(MAX_W);
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (load_o) begin
                        n_q     <= n_i;
                        iter_q  <= '0;
                        state_q <= ST_ADD;
                    end
                end
                ST_ADD: state_q <= ST_SHIFT;
                ST_SHIFT: begin
                    if (last) begin
                        state_q <= ST_IDLE;
                        iter_q  <= '0;
                        done_q  <= 1'b1;
                    end else begin
                        iter_q  <= iter_q + CW'(1);
                        state_q <= ST_ADD;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign state_o = state_q;
    assign iter_o  = iter_q;
    assign busy_o  = (state_q != ST_IDLE);
    assign done_o  = done_q;

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);
    p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (state_q == ST_IDLE));
    p_iter_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |-> (WW'(iter_q) < n_q));
    p_add_then_shift_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ADD) |=> (state_q == ST_SHIFT));
    p_busy_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> $stable(n_q));
    p_n_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (n_q != '0) && (n_q <= WW'(MAX_W)));
endmodule

// File: rtl/mul_datapath.sv
// Three-register datapath: left-moving multiplicand, right-moving multiplier,
// and an accumulating product.
// Assumes: at most one of load/add/shift is active in a cycle.
module mul_datapath #(
    parameter int MAX_W = 32,
    localparam int DW   = 2 * MAX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             add_en_i,
    input  logic             shift_en_i,
    input  logic [MAX_W-1:0] a_i,
    input  logic [MAX_W-1:0] b_i,
    output logic [DW-1:0]    mcand_o,
    output logic [MAX_W-1:0] mplier_o,
    output logic [DW-1:0]    prod_o
);
    logic [DW-1:0]    mcand_q;
    logic [MAX_W-1:0] mplier_q;
    logic [DW-1:0]    prod_q;
    logic [DW-1:0]    sum;

    mul_adder #(.DW(DW)) u_adder (
        .x_i   (prod_q),
        .y_i   (mcand_q),
        .sum_o (sum)
    );

    // Operand registers: load on start, move one place on each shift step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mcand_q  <= '0;
            mplier_q <= '0;
        end else if (load_i) begin
            mcand_q  <= {{MAX_W{1'b0}}, a_i};
            mplier_q <= b_i;
        end else if (shift_en_i) begin
            mcand_q  <= {mcand_q[DW-2:0], 1'b0};
            mplier_q <= {1'b0, mplier_q[MAX_W-1:1]};
        end
    end

    // Product register: clear on start, accumulate when the low multiplier bit is set.
    always_ff @(posedge clk) begin
        if (!rst_n)
            prod_q <= '0;
        else if (load_i)
            prod_q <= '0;
        else if (add_en_i && mplier_q[0])
            prod_q <= sum;
    end

    assign mcand_o  = mcand_q;
    assign mplier_o = mplier_q;
    assign prod_o   = prod_q;

    p_skip_add_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (add_en_i && !mplier_q[0]) |=> $stable(prod_q));
    p_do_add_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (add_en_i && mplier_q[0]) |=> (prod_q == $past(prod_q) + $past(mcand_q)));
    p_load_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (prod_q == '0) && (mcand_q[DW-1:MAX_W] == '0));
    p_zero_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en_i |=> (!mcand_q[0] && !mplier_q[MAX_W-1]));
    p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !add_en_i && !shift_en_i) |=> $stable(prod_q) && $stable(mcand_q));
endmodule

// File: rtl/shift_add_mul.sv
// Top level of the iterative unsigned shift-add multiplier.
// Assumes: synchronous active-low reset. start_i is honoured only while idle.
module shift_add_mul
    import mul_pkg::*;
#(
    parameter int MAX_W = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start_i,
    input  logic [MAX_W-1:0]           a_i,
    input  logic [MAX_W-1:0]           b_i,
    input  logic [$clog2(MAX_W+1)-1:0] width_i,
    output logic                       busy_o,
    output logic                       done_o,
    output logic [2*MAX_W-1:0]         product_o,
    output logic [2*MAX_W-1:0]         mcand_o,
    output logic [MAX_W-1:0]           mplier_o,
    output logic [1:0]                 step_o,
    output logic [$clog2(MAX_W)-1:0]   iter_o
);
    localparam int WW = $clog2(MAX_W + 1);
    localparam int CW = $clog2(MAX_W);

    logic [WW-1:0]    n_sel;
    logic [MAX_W-1:0] a_m;
    logic [MAX_W-1:0] b_m;
    mul_state_e       state;
    logic             load;

    mul_width_ctl #(.MAX_W(MAX_W), .WW(WW)) u_width (
        .width_i  (width_i),
        .a_i      (a_i),
        .b_i      (b_i),
        .n_o      (n_sel),
        .a_mask_o (a_m),
        .b_mask_o (b_m)
    );

    mul_ctrl #(.MAX_W(MAX_W), .WW(WW), .CW(CW)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .n_i     (n_sel),
        .state_o (state),
        .iter_o  (iter_o),
        .load_o  (load),
        .busy_o  (busy_o),
        .done_o  (done_o)
    );

    mul_datapath #(.MAX_W(MAX_W)) u_dp (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .add_en_i   (state == ST_ADD),
        .shift_en_i (state == ST_SHIFT),
        .a_i        (a_m),
        .b_i        (b_m),
        .mcand_o    (mcand_o),
        .mplier_o   (mplier_o),
        .prod_o     (product_o)
    );

    assign step_o = state;

    p_step_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
        step_o != 2'd3);
    p_done_not_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);
endmodule

// File: tb/shift_add_mul_tb.sv
module shift_add_mul_tb;
    localparam int CLK_PERIOD = 10;
    localparam int W = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [W-1:0]  a = '0, b = '0;
    logic [5:0]    width = '0;
    logic          busy, done;
    logic [63:0]   product, mcand;
    logic [W-1:0]  mplier;
    logic [1:0]    step;
    logic [4:0]    iter;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit cmp_en   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    shift_add_mul #(.MAX_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .a_i(a), .b_i(b),
        .width_i(width), .busy_o(busy), .done_o(done), .product_o(product),
        .mcand_o(mcand), .mplier_o(mplier), .step_o(step), .iter_o(iter)
    );

    // Behavioural reference model
    int          m_phase;
    int          m_it, m_n;
    logic [63:0] m_mc, m_pr;
    logic [31:0] m_mp;
    bit          m_done;
    logic [63:0] exp_q[$];

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_it = 0; m_n = 32; m_mc = 0; m_pr = 0; m_mp = 0; m_done = 0;
        end else begin
            m_done = 0;
            if (m_phase == 0) begin
                if (start) begin
                    logic [31:0] msk;
                    m_n = (width == 0 || width > 32) ? 32 : int'(width);
                    msk = '0;
                    for (int i = 0; i < m_n; i++) msk[i] = 1'b1;
                    m_mc = {32'd0, a & msk};
                    m_mp = b & msk;
                    m_pr = 0;
                    m_it = 0;
                    m_phase = 1;
                    exp_q.push_back(64'(a & msk) * 64'(b & msk));
                end
            end else if (m_phase == 1) begin
                if (m_mp[0]) m_pr = m_pr + m_mc;
                m_phase = 2;
            end else begin
                m_mc = m_mc << 1;
                m_mp = m_mp >> 1;
                if (m_it == m_n - 1) begin
                    m_phase = 0; m_it = 0; m_done = 1;
                end else begin
                    m_it++; m_phase = 1;
                end
            end
        end
    end

    // Per-cycle comparison against the model, plus watchdog
    always @(negedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=<100000", cyc);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
        if (cmp_en) begin
            chk(product == m_pr, "R3 product", product, m_pr);
            chk(mcand == m_mc, "R4 multiplicand", mcand, m_mc);
            chk(mplier == m_mp, "R4 multiplier", {32'd0, mplier}, {32'd0, m_mp});
            chk(step == 2'(m_phase), "R9 step code", {62'd0, step}, 64'(m_phase));
            chk(iter == 5'(m_it), "R9 iteration", {59'd0, iter}, 64'(m_it));
            chk(busy == (m_phase != 0), "R2 busy", {63'd0, busy}, 64'(m_phase != 0));
            chk(done == m_done, "R7 done", {63'd0, done}, {63'd0, m_done});
            if (done) begin
                logic [63:0] e;
                e = (exp_q.size() > 0) ? exp_q.pop_front() : 64'hDEAD;
                chk(product == e, "R5 final product", product, e);
            end
        end
    end

    task automatic pulse_start(input logic [31:0] aa, input logic [31:0] bb, input logic [5:0] ww);
        @(negedge clk);
        a = aa; b = bb; width = ww; start = 1'b1;
        @(negedge clk);
        start = 1'b0; a = '0; b = '0; width = '0;
    endtask

    task automatic wait_done();
        for (int k = 0; k < 200; k++) begin
            if (done) return;
            @(negedge clk);
        end
        chk(1'b0, "R5 done timeout", 0, 1);
    endtask

    task automatic run(input logic [31:0] aa, input logic [31:0] bb, input logic [5:0] ww);
        pulse_start(aa, bb, ww);
        wait_done();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!busy && !done && product == 0 && mcand == 0 && mplier == 0 && step == 0 && iter == 0,
            "R1 reset state", product, 0);
        rst_n = 1'b1;
        cmp_en = 1'b1;
        @(negedge clk);
        chk(!busy && step == 0, "R1 after release", {62'd0, step}, 0);

        // R10: 50 * 10 at width 6
        run(32'd50, 32'd10, 6'd6);
        chk(product == 64'd500, "R10 50x10", product, 500);

        // R7: product stays while idle
        repeat (5) @(negedge clk);
        chk(product == 64'd500 && !busy, "R7 hold idle", product, 500);

        // R5: full width maximum operands
        run(32'hFFFF_FFFF, 32'hFFFF_FFFF, 6'd32);
        chk(product == 64'hFFFF_FFFE_0000_0001, "R5 max width", product, 64'hFFFF_FFFE_0000_0001);

        // R5: width 1
        run(32'd1, 32'd1, 6'd1);
        chk(product == 64'd1, "R5 width one", product, 1);

        // R6: masking above n
        run(32'hFFFF_FFF3, 32'hFFFF_FFF5, 6'd4);
        chk(product == 64'd15, "R6 mask", product, 15);

        // R6: width 0 and above-maximum clamp to 32
        run(32'h8000_0000, 32'd2, 6'd0);
        chk(product == 64'h1_0000_0000, "R6 clamp zero", product, 64'h1_0000_0000);
        run(32'h8000_0001, 32'd3, 6'd45);
        chk(product == 64'h1_8000_0003, "R6 clamp high", product, 64'h1_8000_0003);

        // R8: start while busy is ignored
        pulse_start(32'd7, 32'd9, 6'd8);
        repeat (3) @(negedge clk);
        pulse_start(32'd200, 32'd200, 6'd3);
        wait_done();
        chk(product == 64'd63, "R8 busy start ignored", product, 63);

        // R2: back-to-back start accepted in the done cycle
        pulse_start(32'd3, 32'd3, 6'd2);
        wait_done();
        start = 1'b1; a = 32'd5; b = 32'd6; width = 6'd3;
        @(negedge clk);
        start = 1'b0;
        chk(busy && product == 0 && mcand == 64'd5, "R2 restart load", mcand, 5);
        wait_done();
        chk(product == 64'd30, "R2 restart result", product, 30);

        // R3/R4: assorted patterns
        for (int t = 0; t < 20; t++) begin
            run($urandom, $urandom, 6'($urandom_range(1, 32)));
        end
        run(32'd0, 32'hABCD, 6'd16);
        chk(product == 0, "R3 zero operand", product, 0);

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R5 queue drained", 64'(exp_q.size()), 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule